// File: doc/BRIEF.md
# Serial Host Port for a Segment LCD Controller

This block is the host-facing slave side of a segment LCD controller. A host processor talks to it over three wires: an active-low chip select, an active-low write strobe and an active-low read strobe, plus one data line. Internally the data line is split into an input pin and an output pin with an output enable, and the pad is left to the chip top. Every host pin is brought into the system clock domain through a synchroniser. The block then finds strobe edges and decodes the serial frames. It keeps a 128-entry by 4-bit display memory, which the host can write, read back, or read and rewrite in one pass. Configuration commands are handed on to the rest of the controller as one-cycle strobes that carry an 8-bit code.

Each select window opens with a 3-bit mode code. A data-mode window then carries a 7-bit start address and a run of 4-bit nibbles, and the address steps forward after each nibble. A command window carries a run of 9-bit command words with no further mode code between them. Raising chip select always ends the window, and the next window must begin with a fresh mode code.

The command strobe is a plain control output with no back-pressure. The serial protocol gives the host no way to stall, so `cmd_valid` is a bare pulse and the consumer must accept it in the cycle it appears.

Top module: `seglcd_serial_port`

## Requirements
- R1: After reset, `data_oe` and `cmd_valid` are low, and no command strobe appears until a full command frame has been received.
- R2: The first three bits captured after chip select falls form the mode code, taken first bit to last as bit 2 down to bit 0. 110 selects read, 101 selects write or read-modify-write, and 100 selects command. Any other code makes the block ignore all strobes until chip select rises.
- R3: Bits are captured from `data_in` on rising write-strobe edges. In a data mode the 7-bit address follows the mode code, most significant bit first. Each 4-bit nibble follows, least significant bit first, and is stored at the current address once its fourth bit has arrived.
- R4: After each complete nibble the address increments by one, so a run of nibbles fills consecutive locations. The address wraps from 127 to 0.
- R5: In read mode each falling read-strobe edge places the next bit on `data_out`, bit 0 of the nibble first. `data_out` holds its value until the next falling read-strobe edge. After bit 3 the address increments, so the next falling edge starts the following location.
- R6: `data_oe` rises only because of a falling read-strobe edge in a data mode. It stays low during write and command transfers, and it returns low when chip select rises and when a write bit arrives in read-modify-write.
- R7: In read-modify-write (mode 101), falling read-strobe edges shift out the nibble at the current address without moving the address. The nibble then written with four write-strobe edges goes to that same address, and only then does the address increment.
- R8: In command mode each 9-bit word yields one `cmd_valid` pulse exactly one cycle long. `cmd_code` carries the first 8 bits, the first bit as bit 7. The ninth bit is ignored, and later words in the same window need no mode code.
- R9: Raising chip select mid-transfer discards the partial nibble or command: memory is not written and no strobe is raised.
- R10: In read mode, write-strobe edges after the address do not modify memory or move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe; a bit is taken on its rising edge |
| rd_n | input | 1 | Host read strobe; a bit is presented after its falling edge |
| data_in | input | 1 | Serial data from the host |
| data_out | output | 1 | Serial read data to the host |
| data_oe | output | 1 | Drive enable for the shared data pad |
| cmd_valid | output | 1 | One-cycle pulse for each completed command word |
| cmd_code | output | 8 | Code of the command word, valid with `cmd_valid` |

## Verification
The bench goes after the address wrap at 127. A design that saturated or ran past the end would put the second nibble somewhere other than location 0. It checks that read-modify-write writes back to the location just read and then advances. A design that moved the address on the read half would corrupt the neighbouring entry. It also cuts transfers short with chip select: a partial nibble that still got stored, or a partial command that was carried into the next window, would show up as a changed location or an extra command pulse. Finally, it sends an unknown mode code and stray write strobes during a read. A decoder that fell through to write mode would change memory in those windows.

// File: rtl/slsp_pkg.sv
package slsp_pkg;

  localparam int ID_W = 3;

  localparam logic [ID_W-1:0] ID_READ  = 3'b110;
  localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
  localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

  typedef enum logic [2:0] {
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_CMD,
    PH_SKIP
  } phase_t;

  typedef enum logic {
    MD_READ,
    MD_WRITE
  } mode_t;

endpackage

// File: rtl/slsp_sync.sv
module slsp_sync #(
  parameter int          N      = 4,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE[g]}};
        else        chain <= {chain[STAGES-2:0], pin[g]};
      end
      assign lvl[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/slsp_edge.sv
module slsp_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = lvl & ~last;
    end else begin : g_fall
      assign pulse = ~lvl & last;
    end
  endgenerate

endmodule

// File: rtl/slsp_nib_ram.sv
module slsp_nib_ram #(
  parameter int AW = 7,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/slsp_frame.sv
module slsp_frame
  import slsp_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DW    = 4,
  parameter int CMD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              wr_rise,
  input  logic              rd_fall,
  input  logic              din,
  input  logic [DW-1:0]     rd_nib,
  output logic [AW-1:0]     cur_addr,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DW-1:0]     ram_wdata,
  output logic              dout,
  output logic              doe,
  output logic              cmd_valid,
  output logic [CMD_W-2:0]  cmd_code
);

  localparam int CODE_W  = CMD_W - 1;
  localparam int CNT_MAX = (CMD_W > AW) ? CMD_W : AW;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RB_W    = (DW > 1) ? $clog2(DW) : 1;

  localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [RB_W-1:0]  RB_LAST   = RB_W'(DW - 1);

  phase_t            phase;
  mode_t             mode;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] shreg;
  logic [AW-1:0]     addr;
  logic [DW-1:0]     nib;
  logic [RB_W-1:0]   rbit;
  logic [ID_W-1:0]   id_now;
  logic [DW-1:0]     nib_done;

  assign id_now   = {shreg[ID_W-2:0], din};
  assign nib_done = {din, nib[DW-1:1]};
  assign cur_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ID;
      mode      <= MD_WRITE;
      cnt       <= '0;
      shreg     <= '0;
      addr      <= '0;
      nib       <= '0;
      rbit      <= '0;
      dout      <= 1'b0;
      doe       <= 1'b0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      ram_we    <= 1'b0;
      cmd_valid <= 1'b0;
      if (cs_idle) begin
        phase <= PH_ID;
        cnt   <= '0;
        rbit  <= '0;
        doe   <= 1'b0;
      end else begin
        case (phase)
          PH_ID: begin
            if (wr_rise) begin
              shreg <= {shreg[CODE_W-2:0], din};
              if (cnt == ID_LAST) begin
                cnt <= '0;
                case (id_now)
                  ID_READ:  begin mode <= MD_READ;  phase <= PH_ADDR; end
                  ID_WRITE: begin mode <= MD_WRITE; phase <= PH_ADDR; end
                  ID_CMD:   phase <= PH_CMD;
                  default:  phase <= PH_SKIP;
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_ADDR: begin
            if (wr_rise) begin
              addr <= {addr[AW-2:0], din};
              if (cnt == ADDR_LAST) begin
                cnt   <= '0;
                rbit  <= '0;
                phase <= PH_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_DATA: begin
            if (rd_fall && (mode == MD_READ || cnt == '0)) begin
              dout <= rd_nib[rbit];
              doe  <= 1'b1;
              rbit <= rbit + 1'b1;
              if (mode == MD_READ && rbit == RB_LAST) addr <= addr + 1'b1;
            end else if (wr_rise && mode == MD_WRITE) begin
              nib <= nib_done;
              doe <= 1'b0;
              if (cnt == NIB_LAST) begin
                cnt       <= '0;
                rbit      <= '0;
                ram_we    <= 1'b1;
                ram_waddr <= addr;
                ram_wdata <= nib_done;
                addr      <= addr + 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_CMD: begin
            if (wr_rise) begin
              if (cnt == CMD_LAST) begin
                cnt       <= '0;
                cmd_valid <= 1'b1;
                cmd_code  <= shreg;
              end else begin
                shreg <= {shreg[CODE_W-2:0], din};
                cnt   <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/seglcd_serial_port.sv
module seglcd_serial_port #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 4,
  parameter int CMD_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             data_in,
  output logic             data_out,
  output logic             data_oe,
  output logic             cmd_valid,
  output logic [CMD_W-2:0] cmd_code
);

  localparam int PINS = 4;

  logic [PINS-1:0]   pin_lvl;
  logic              cs_idle;
  logic              wr_rise;
  logic              rd_fall;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_nib;

  slsp_sync #(
    .N      (PINS),
    .STAGES (SYNC_STAGES),
    .IDLE   ('1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({data_in, rd_n, wr_n, cs_n}),
    .lvl   (pin_lvl)
  );

  assign cs_idle = pin_lvl[0];

  slsp_edge #(.RISING(1'b1)) u_wr_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl[1]),
    .pulse (wr_rise)
  );

  slsp_edge #(.RISING(1'b0)) u_rd_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl[2]),
    .pulse (rd_fall)
  );

  slsp_nib_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (cur_addr),
    .rdata (rd_nib)
  );

  slsp_frame #(.AW(ADDR_W), .DW(DATA_W), .CMD_W(CMD_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_idle   (cs_idle),
    .wr_rise   (wr_rise),
    .rd_fall   (rd_fall),
    .din       (pin_lvl[3]),
    .rd_nib    (rd_nib),
    .cur_addr  (cur_addr),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .dout      (data_out),
    .doe       (data_oe),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

endmodule

// File: rtl/seglcd_serial_port_chk.sv
module seglcd_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_idle,
  input logic wr_rise,
  input logic rd_fall,
  input logic ram_we,
  input logic data_oe,
  input logic data_out,
  input logic cmd_valid
);

  // R8
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R8
  cmd_quiet_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !data_oe);

  // R6
  oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(rd_fall));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!data_oe && !cmd_valid && !ram_we));

  // R3
  we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(wr_rise));

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> $stable(data_out));

endmodule

bind seglcd_serial_port seglcd_serial_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_idle   (cs_idle),
  .wr_rise   (wr_rise),
  .rd_fall   (rd_fall),
  .ram_we    (ram_we),
  .data_oe   (data_oe),
  .data_out  (data_out),
  .cmd_valid (cmd_valid)
);

// File: tb/seglcd_serial_port_bench.sv
module seglcd_serial_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       data_in = 1'b1;
  logic       data_out;
  logic       data_oe;
  logic       cmd_valid;
  logic [7:0] cmd_code;

  int n_checks = 0;
  int n_fails  = 0;
  int n_cmds   = 0;
  logic [7:0] cmd_log [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  seglcd_serial_port u_seglcd_serial_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .data_in   (data_in),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      if (n_cmds < 16) cmd_log[n_cmds] = cmd_code;
      n_cmds = n_cmds + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_win();
    cs_n = 1'b0;
    idle(HOLD);
  endtask

  task automatic close_win();
    cs_n = 1'b1;
    idle(HOLD);
  endtask

  task automatic wr_bit(input logic b);
    data_in = b;
    wr_n = 1'b0;
    idle(HOLD);
    wr_n = 1'b1;
    idle(HOLD);
  endtask

  task automatic rd_bit(output logic b);
    rd_n = 1'b0;
    idle(HOLD);
    b = data_out;
    rd_n = 1'b1;
    idle(HOLD);
  endtask

  task automatic send_msb(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(val[i]);
  endtask

  task automatic send_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wr_bit(v[i]);
  endtask

  task automatic get_nib(output logic [3:0] v);
    logic b;
    for (int i = 0; i < 4; i++) begin
      rd_bit(b);
      v[i] = b;
    end
  endtask

  task automatic write_one(input int addr, input logic [3:0] v);
    open_win();
    send_msb(3'b101, 3);
    send_msb(addr, 7);
    send_nib(v);
    close_win();
  endtask

  task automatic read_one(input int addr, output logic [3:0] v);
    open_win();
    send_msb(3'b110, 3);
    send_msb(addr, 7);
    get_nib(v);
    close_win();
  endtask

  task automatic t_reset();
    check("R1 data_oe after reset", data_oe, 0);
    check("R1 cmd_valid after reset", cmd_valid, 0);
    check("R1 no command pulses", n_cmds, 0);
  endtask

  task automatic t_single();
    logic [3:0] v;
    write_one(5, 4'hA);
    read_one(5, v);
    check("R3 single write/read addr 5", v, 4'hA);
    write_one(6, 4'h1);
    read_one(6, v);
    check("R3 bit order addr 6", v, 4'h1);
  endtask

  task automatic t_burst();
    logic [3:0] v;
    open_win();
    send_msb(3'b101, 3);
    send_msb(10, 7);
    for (int i = 0; i < 4; i++) send_nib(4'(i + 1));
    close_win();
    open_win();
    send_msb(3'b110, 3);
    send_msb(10, 7);
    for (int i = 0; i < 4; i++) begin
      get_nib(v);
      check("R4 R5 burst read", v, i + 1);
    end
    close_win();
  endtask

  task automatic t_wrap();
    logic [3:0] v;
    open_win();
    send_msb(3'b101, 3);
    send_msb(127, 7);
    send_nib(4'h7);
    send_nib(4'h9);
    close_win();
    read_one(0, v);
    check("R4 wrap to addr 0", v, 4'h9);
    open_win();
    send_msb(3'b110, 3);
    send_msb(127, 7);
    get_nib(v);
    check("R4 read at 127", v, 4'h7);
    get_nib(v);
    check("R4 read wraps to 0", v, 4'h9);
    close_win();
  endtask

  task automatic t_oe();
    logic b;
    open_win();
    send_msb(3'b101, 3);
    send_msb(64, 7);
    wr_bit(1'b1);
    check("R6 oe low in write", data_oe, 0);
    close_win();
    open_win();
    send_msb(3'b110, 3);
    send_msb(64, 7);
    check("R6 oe low before read strobe", data_oe, 0);
    rd_bit(b);
    check("R6 oe high after read strobe", data_oe, 1);
    close_win();
    check("R6 oe low after deselect", data_oe, 0);
  endtask

  task automatic t_rmw();
    logic [3:0] v;
    write_one(20, 4'h3);
    write_one(21, 4'h5);
    open_win();
    send_msb(3'b101, 3);
    send_msb(20, 7);
    get_nib(v);
    check("R7 rmw read addr 20", v, 4'h3);
    check("R6 oe high in rmw read", data_oe, 1);
    wr_bit(1'b0);
    check("R6 oe low after rmw write bit", data_oe, 0);
    wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b1);
    get_nib(v);
    check("R7 rmw read addr 21", v, 4'h5);
    send_nib(4'h6);
    close_win();
    read_one(20, v);
    check("R7 rmw wrote addr 20", v, 4'hC);
    read_one(21, v);
    check("R7 rmw wrote addr 21", v, 4'h6);
  endtask

  task automatic t_cmd();
    int base;
    base = n_cmds;
    open_win();
    send_msb(3'b100, 3);
    send_msb(8'h03, 8); wr_bit(1'b1);
    send_msb(8'h18, 8); wr_bit(1'b0);
    send_msb(8'hA5, 8); wr_bit(1'b1);
    close_win();
    check("R8 three command pulses", n_cmds - base, 3);
    check("R8 first code", cmd_log[base], 8'h03);
    check("R8 second code no id", cmd_log[base + 1], 8'h18);
    check("R8 third code no id", cmd_log[base + 2], 8'hA5);
  endtask

  task automatic t_abort();
    logic [3:0] v;
    int base;
    write_one(30, 4'hF);
    open_win();
    send_msb(3'b101, 3);
    send_msb(30, 7);
    wr_bit(1'b0); wr_bit(1'b0);
    close_win();
    read_one(30, v);
    check("R9 partial nibble dropped", v, 4'hF);
    base = n_cmds;
    open_win();
    send_msb(3'b100, 3);
    send_msb(5'b10101, 5);
    close_win();
    open_win();
    send_msb(9'b000000011, 9);
    close_win();
    check("R9 no command after abort", n_cmds - base, 0);
  endtask

  task automatic t_bad_id();
    logic [3:0] v;
    write_one(40, 4'h2);
    open_win();
    send_msb(3'b111, 3);
    send_msb(40, 7);
    send_nib(4'h5);
    close_win();
    read_one(40, v);
    check("R2 unknown mode ignored", v, 4'h2);
  endtask

  task automatic t_read_ignores_wr();
    logic [3:0] v;
    write_one(50, 4'hB);
    open_win();
    send_msb(3'b110, 3);
    send_msb(50, 7);
    send_nib(4'h0);
    get_nib(v);
    check("R10 wr strobes ignored in read", v, 4'hB);
    close_win();
    read_one(50, v);
    check("R10 memory unchanged", v, 4'hB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_single();
    t_burst();
    t_wrap();
    t_oe();
    t_rmw();
    t_cmd();
    t_abort();
    t_bad_id();
    t_read_ignores_wr();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule